// File: doc/BRIEF.md
# Chunked I2C Master Transfer Sequencer

This block sits between a message-level request and a byte-level I2C master engine that can move at most four bytes per command. A message arrives as a length, a direction and a flag that says whether another message to the same target follows it. The sequencer splits the message into chunks of up to four bytes. For each chunk it runs the data handshake: a write fills the engine's buffer before the command goes out, and a read empties the buffer after the command completes. It then issues a control word and waits for the engine to report how many bytes actually moved.

Every chunk except the final one asks the engine to keep the bus. The final chunk of a message that is followed by another one asks for a repeated start in place of a stop. A short count, or an engine that never answers within a parameterised number of cycles, ends the message with an error code. In the cases where the bus may still be held, the sequencer also sends an abort. It then gives the bus a bounded number of cycles to come free, and asks for a soft reset if it does not. A zero-length request is answered at once and never reaches the engine.

Top module: `i2cseq_top`

## Requirements
- R1: A message of length L (1..2^LEN_W-1) produces (L+3)/4 commands. Each command carries min(remaining, 4) bytes, encoded in `cmd_tct` as the byte count minus one.
- R2: `cmd_chain` is 1 on every command of a message except the last, and 0 on the last.
- R3: `cmd_rpt` is 1 only on the last command of a message started with `msg_comb`=1. It is never 1 together with `cmd_chain`.
- R4: For a write (`msg_rd`=0), exactly as many `byte_load` pulses as the chunk's byte count come before each `cmd_valid`. For a read, `byte_load` never pulses. After each fully completed read chunk, exactly its byte count of `byte_unload` pulses follow.
- R5: If `eng_count` differs from the chunk's byte count, the message ends with status 1. `eng_abort` pulses once if that chunk was not the last or the message is combined. Otherwise no abort is sent and no further command is issued.
- R6: If `eng_done` does not arrive within TIMEOUT cycles of waiting, `eng_abort` pulses TIMEOUT+1 cycles after the `cmd_valid` cycle, and the message ends with status 2.
- R7: After an abort, if `bus_free` is seen high within FREE_WAIT cycles the message ends without `soft_reset`. Otherwise `soft_reset` pulses once, FREE_WAIT+1 cycles after the `eng_abort` cycle, and then the message ends.
- R8: `msg_start` with `msg_len`=0 while idle raises `msg_done` in the same cycle with status 3. It issues no command and leaves `busy` low.
- R9: A message whose every chunk completes with the full count ends with a one-cycle `msg_done` and status 0. `msg_start` is ignored while `busy` is high.
- R10: After reset the block is idle: `busy`, `msg_done`, `cmd_valid`, `byte_load`, `byte_unload`, `eng_abort` and `soft_reset` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_start | input | 1 | Start a message (sampled while idle) |
| msg_len | input | LEN_W | Message length in bytes |
| msg_rd | input | 1 | 1 = read, 0 = write |
| msg_comb | input | 1 | Another message follows; end with repeated start |
| busy | output | 1 | A message is in progress |
| msg_done | output | 1 | One-cycle end-of-message strobe |
| msg_status | output | 2 | 0 ok, 1 count mismatch, 2 timeout, 3 empty; valid with msg_done |
| byte_load | output | 1 | Load one write byte into the engine buffer |
| byte_unload | output | 1 | Take one read byte from the engine buffer |
| cmd_valid | output | 1 | One-cycle command strobe to the engine |
| cmd_tct | output | 2 | Chunk byte count minus one |
| cmd_rd | output | 1 | Chunk direction |
| cmd_chain | output | 1 | Keep the bus after this chunk |
| cmd_rpt | output | 1 | End this chunk with a repeated start |
| eng_done | input | 1 | Engine completion strobe |
| eng_count | input | 3 | Bytes the engine actually moved |
| eng_abort | output | 1 | One-cycle abort request to the engine |
| bus_free | input | 1 | Bus is idle |
| soft_reset | output | 1 | One-cycle soft-reset request |

## Verification
The properties assume the engine returns `eng_done` as a single-cycle strobe, and only while a command is outstanding. They also assume `bus_free` is only consulted after an abort. The bench engine model raises `eng_done` once per command, after a set delay, and never otherwise. It drops `bus_free` at the abort and raises it again after a programmed delay, or never. New messages are only launched while `busy` is low, with the single deliberate exception that probes whether a start is ignored mid-message.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    localparam int CHUNK_MAX = 4;
    localparam int CNT_W     = $clog2(CHUNK_MAX + 1);
    localparam int TCT_W     = $clog2(CHUNK_MAX);

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_COUNT   = 2'd1,
        ST_TIMEOUT = 2'd2,
        ST_EMPTY   = 2'd3
    } seq_status_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOAD,
        S_ISSUE,
        S_WAIT,
        S_UNLOAD,
        S_ABORT,
        S_FREEWAIT,
        S_RESET,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic [TCT_W-1:0] tct;
        logic             rd;
        logic             chain;
        logic             rpt;
    } cmd_word_t;

    function automatic logic [TCT_W-1:0] encode_tct(input logic [CNT_W-1:0] n);
        return TCT_W'(n - CNT_W'(1));
    endfunction

endpackage

// File: rtl/i2cseq_chunker.sv
module i2cseq_chunker
    import i2cseq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic [LEN_W-1:0] remaining,
    output logic [CNT_W-1:0] chunk_cnt,
    output logic             chunk_last
);
    localparam logic [LEN_W-1:0] MAXC = LEN_W'(CHUNK_MAX);

    always_comb begin
        if (remaining >= MAXC) begin
            chunk_cnt = CNT_W'(CHUNK_MAX);
        end else begin
            chunk_cnt = CNT_W'(remaining);
        end
        chunk_last = (remaining <= MAXC);
    end
endmodule

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count_q <= '0;
        end else if (count_q != LAST) begin
            count_q <= count_q + TW'(1);
        end
    end

    assign expired = run && (count_q == LAST);
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int TIMEOUT   = 1000,
    parameter int FREE_WAIT = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             msg_start,
    input  logic [LEN_W-1:0] msg_len,
    input  logic             msg_rd,
    input  logic             msg_comb,
    output logic             busy,
    output logic             msg_done,
    output logic [1:0]       msg_status,
    output logic             byte_load,
    output logic             byte_unload,
    output logic             cmd_valid,
    output logic [1:0]       cmd_tct,
    output logic             cmd_rd,
    output logic             cmd_chain,
    output logic             cmd_rpt,
    input  logic             eng_done,
    input  logic [2:0]       eng_count,
    output logic             eng_abort,
    input  logic             bus_free,
    output logic             soft_reset
);
    seq_state_e       state_q, state_d;
    logic [LEN_W-1:0] rem_q, rem_d;
    logic             rd_q, rd_d;
    logic             comb_q, comb_d;
    seq_status_e      stat_q, stat_d;
    logic [CNT_W-1:0] bidx_q, bidx_d;

    logic [CNT_W-1:0] chunk_cnt;
    logic             chunk_last;
    logic             tmo_exp, free_exp;
    logic             last_byte;
    cmd_word_t        cmd_w;

    i2cseq_chunker #(.LEN_W(LEN_W)) u_chunk (
        .remaining  (rem_q),
        .chunk_cnt  (chunk_cnt),
        .chunk_last (chunk_last)
    );

    i2cseq_timer #(.LIMIT(TIMEOUT)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == S_WAIT),
        .expired (tmo_exp)
    );

    i2cseq_timer #(.LIMIT(FREE_WAIT)) u_free (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == S_FREEWAIT),
        .expired (free_exp)
    );

    assign last_byte = (bidx_q == chunk_cnt - CNT_W'(1));

    always_comb begin
        cmd_w.tct   = encode_tct(chunk_cnt);
        cmd_w.rd    = rd_q;
        cmd_w.chain = !chunk_last;
        cmd_w.rpt   = chunk_last && comb_q;
    end

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        rd_d    = rd_q;
        comb_d  = comb_q;
        stat_d  = stat_q;
        bidx_d  = bidx_q;
        unique case (state_q)
            S_IDLE: begin
                if (msg_start && (msg_len != '0)) begin
                    rem_d   = msg_len;
                    rd_d    = msg_rd;
                    comb_d  = msg_comb;
                    stat_d  = ST_OK;
                    bidx_d  = '0;
                    state_d = msg_rd ? S_ISSUE : S_LOAD;
                end
            end
            S_LOAD: begin
                bidx_d = bidx_q + CNT_W'(1);
                if (last_byte) begin
                    bidx_d  = '0;
                    state_d = S_ISSUE;
                end
            end
            S_ISSUE: begin
                state_d = S_WAIT;
            end
            S_WAIT: begin
                if (eng_done) begin
                    if (eng_count == chunk_cnt) begin
                        if (rd_q) begin
                            bidx_d  = '0;
                            state_d = S_UNLOAD;
                        end else begin
                            rem_d   = rem_q - LEN_W'(chunk_cnt);
                            state_d = chunk_last ? S_DONE : S_LOAD;
                        end
                    end else begin
                        stat_d  = ST_COUNT;
                        state_d = (!chunk_last || comb_q) ? S_ABORT : S_DONE;
                    end
                end else if (tmo_exp) begin
                    stat_d  = ST_TIMEOUT;
                    state_d = S_ABORT;
                end
            end
            S_UNLOAD: begin
                bidx_d = bidx_q + CNT_W'(1);
                if (last_byte) begin
                    bidx_d  = '0;
                    rem_d   = rem_q - LEN_W'(chunk_cnt);
                    state_d = chunk_last ? S_DONE : S_ISSUE;
                end
            end
            S_ABORT: begin
                state_d = S_FREEWAIT;
            end
            S_FREEWAIT: begin
                if (bus_free) begin
                    state_d = S_DONE;
                end else if (free_exp) begin
                    state_d = S_RESET;
                end
            end
            S_RESET: begin
                state_d = S_DONE;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            rem_q   <= '0;
            rd_q    <= 1'b0;
            comb_q  <= 1'b0;
            stat_q  <= ST_OK;
            bidx_q  <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            rd_q    <= rd_d;
            comb_q  <= comb_d;
            stat_q  <= stat_d;
            bidx_q  <= bidx_d;
        end
    end

    logic empty_req;
    assign empty_req = (state_q == S_IDLE) && msg_start && (msg_len == '0);

    always_comb begin
        busy        = (state_q != S_IDLE);
        byte_load   = (state_q == S_LOAD);
        byte_unload = (state_q == S_UNLOAD);
        cmd_valid   = (state_q == S_ISSUE);
        eng_abort   = (state_q == S_ABORT);
        soft_reset  = (state_q == S_RESET);
        msg_done    = (state_q == S_DONE) || empty_req;
        if (state_q == S_DONE) begin
            msg_status = stat_q;
        end else if (empty_req) begin
            msg_status = ST_EMPTY;
        end else begin
            msg_status = 2'd0;
        end
        if (cmd_valid) begin
            cmd_tct   = cmd_w.tct;
            cmd_rd    = cmd_w.rd;
            cmd_chain = cmd_w.chain;
            cmd_rpt   = cmd_w.rpt;
        end else begin
            cmd_tct   = '0;
            cmd_rd    = 1'b0;
            cmd_chain = 1'b0;
            cmd_rpt   = 1'b0;
        end
    end
endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             msg_start,
    input logic [LEN_W-1:0] msg_len,
    input logic             busy,
    input logic             msg_done,
    input logic [1:0]       msg_status,
    input logic             byte_load,
    input logic             byte_unload,
    input logic             cmd_valid,
    input logic             cmd_chain,
    input logic             cmd_rpt,
    input logic             eng_abort,
    input logic             bus_free,
    input logic             soft_reset
);
    // R3
    chain_rpt_excl_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !(cmd_chain && cmd_rpt));

    // R1
    cmd_single_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R4
    load_unload_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({byte_load, byte_unload, cmd_valid}));

    // R6
    abort_single_chk: assert property (@(posedge clk) disable iff (rst)
        eng_abort |=> !eng_abort);

    // R7
    reset_needs_stuck_bus_chk: assert property (@(posedge clk) disable iff (rst)
        soft_reset |-> $past(!bus_free));

    // R8
    empty_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && msg_start && msg_len == '0) |-> (msg_done && msg_status == 2'd3));

    // R9
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_done && busy) |=> !busy);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(cmd_valid || byte_load || byte_unload || eng_abort || soft_reset));
endmodule

bind i2cseq_top i2cseq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .msg_start   (msg_start),
    .msg_len     (msg_len),
    .busy        (busy),
    .msg_done    (msg_done),
    .msg_status  (msg_status),
    .byte_load   (byte_load),
    .byte_unload (byte_unload),
    .cmd_valid   (cmd_valid),
    .cmd_chain   (cmd_chain),
    .cmd_rpt     (cmd_rpt),
    .eng_abort   (eng_abort),
    .bus_free    (bus_free),
    .soft_reset  (soft_reset)
);

// File: tb/tb_i2cseq_top.sv
`timescale 1ns/1ps
module tb_i2cseq_top;
    localparam int LEN_W     = 8;
    localparam int TIMEOUT   = 20;
    localparam int FREE_WAIT = 8;

    typedef struct {
        int tct;
        bit rd;
        bit chain;
        bit rpt;
    } exp_cmd_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             msg_start = 1'b0;
    logic [LEN_W-1:0] msg_len = '0;
    logic             msg_rd = 1'b0;
    logic             msg_comb = 1'b0;
    logic             busy, msg_done, byte_load, byte_unload, cmd_valid;
    logic [1:0]       msg_status, cmd_tct;
    logic             cmd_rd, cmd_chain, cmd_rpt, eng_abort, soft_reset;
    logic             eng_done = 1'b0;
    logic [2:0]       eng_count = '0;
    logic             bus_free = 1'b1;

    always #5 clk = ~clk;

    i2cseq_top #(.LEN_W(LEN_W), .TIMEOUT(TIMEOUT), .FREE_WAIT(FREE_WAIT)) dut (
        .clk(clk), .rst(rst), .msg_start(msg_start), .msg_len(msg_len),
        .msg_rd(msg_rd), .msg_comb(msg_comb), .busy(busy), .msg_done(msg_done),
        .msg_status(msg_status), .byte_load(byte_load), .byte_unload(byte_unload),
        .cmd_valid(cmd_valid), .cmd_tct(cmd_tct), .cmd_rd(cmd_rd),
        .cmd_chain(cmd_chain), .cmd_rpt(cmd_rpt), .eng_done(eng_done),
        .eng_count(eng_count), .eng_abort(eng_abort), .bus_free(bus_free),
        .soft_reset(soft_reset)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    exp_cmd_t exp_q[$];
    int  cyc = 0;
    int  n_cmd, n_load, n_unload, n_abort, n_reset, load_since_cmd;
    bit  done_flag;
    int  done_status;
    int  cmd_cyc, abort_cyc, reset_cyc;
    bit  cur_rd;
    int  eng_delay = 2;
    int  short_idx = -1;
    int  silent_idx = -1;
    int  free_after = 0;
    int  resp_timer = -1;
    int  resp_cnt = 0;
    int  free_timer = -1;

    function automatic void check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endfunction

    // Engine model and cycle-by-cycle comparison against the expected command list
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            eng_done = 1'b0;
            if (!rst) begin
                if (byte_load) begin n_load++; load_since_cmd++; end
                if (byte_unload) n_unload++;
                if (cmd_valid) begin
                    exp_cmd_t e;
                    check(exp_q.size() > 0, "R1 unexpected command", n_cmd, exp_q.size());
                    if (exp_q.size() > 0) begin
                        e = exp_q.pop_front();
                        check(int'(cmd_tct) == e.tct, "R1 tct", int'(cmd_tct), e.tct);
                        check(cmd_rd == e.rd, "R4 cmd_rd", int'(cmd_rd), int'(e.rd));
                        check(cmd_chain == e.chain, "R2 chain", int'(cmd_chain), int'(e.chain));
                        check(cmd_rpt == e.rpt, "R3 rpt", int'(cmd_rpt), int'(e.rpt));
                        check(load_since_cmd == (e.rd ? 0 : e.tct + 1), "R4 loads before cmd",
                              load_since_cmd, e.rd ? 0 : e.tct + 1);
                    end
                    load_since_cmd = 0;
                    cmd_cyc = cyc;
                    if (n_cmd != silent_idx) begin
                        resp_timer = eng_delay;
                        resp_cnt = (n_cmd == short_idx) ? int'(cmd_tct) : int'(cmd_tct) + 1;
                    end
                    n_cmd++;
                end
                if (resp_timer > 0) resp_timer--;
                else if (resp_timer == 0) begin
                    eng_done = 1'b1;
                    eng_count = 3'(resp_cnt);
                    resp_timer = -1;
                end
                if (eng_abort) begin
                    n_abort++;
                    abort_cyc = cyc;
                    bus_free = 1'b0;
                    free_timer = free_after;
                end else if (free_timer > 0) free_timer--;
                else if (free_timer == 0) begin
                    bus_free = 1'b1;
                    free_timer = -1;
                end
                if (soft_reset) begin n_reset++; reset_cyc = cyc; end
                if (msg_done && busy) begin
                    done_flag = 1'b1;
                    done_status = int'(msg_status);
                end
            end
        end
    end

    task automatic clear_counts();
        n_cmd = 0; n_load = 0; n_unload = 0; n_abort = 0; n_reset = 0;
        load_since_cmd = 0; done_flag = 0; done_status = -1;
        exp_q.delete();
    endtask

    task automatic run_msg(input int len, input bit rd, input bit comb,
                           input int sh, input int sil, input int fa,
                           input int exp_status, input int exp_abort,
                           input int exp_reset, input bit poke, input string tag);
        int nch, stop, loads, unloads, rem;
        clear_counts();
        short_idx = sh; silent_idx = sil; free_after = fa;
        nch = (len + 3) / 4;
        stop = (sh >= 0) ? sh : ((sil >= 0) ? sil : nch - 1);
        loads = 0; unloads = 0; rem = len;
        for (int i = 0; i <= stop; i++) begin
            exp_cmd_t e;
            int c;
            c = (rem > 4) ? 4 : rem;
            e.tct = c - 1; e.rd = rd; e.chain = (i != nch - 1);
            e.rpt = (i == nch - 1) && comb;
            exp_q.push_back(e);
            if (!rd) loads += c;
            if (rd && i != stop) unloads += c;
            if (rd && i == stop && sh < 0 && sil < 0) unloads += c;
            rem -= c;
        end
        cur_rd = rd;
        @(negedge clk);
        msg_start = 1'b1; msg_len = LEN_W'(len); msg_rd = rd; msg_comb = comb;
        @(negedge clk);
        msg_start = 1'b0;
        if (poke) begin
            @(negedge clk);
            msg_start = 1'b1; msg_len = 8'd4; msg_rd = !rd; msg_comb = 1'b1;
            @(negedge clk);
            msg_start = 1'b0;
        end
        for (int w = 0; w < 20000 && !done_flag; w++) @(negedge clk);
        #1;
        check(done_flag, {tag, " R9 message completes"}, int'(done_flag), 1);
        check(done_status == exp_status, {tag, " status"}, done_status, exp_status);
        check(n_cmd == stop + 1, {tag, " R1 command count"}, n_cmd, stop + 1);
        check(exp_q.size() == 0, {tag, " R1 commands left"}, exp_q.size(), 0);
        check(n_load == loads, {tag, " R4 load total"}, n_load, loads);
        check(n_unload == unloads, {tag, " R4 unload total"}, n_unload, unloads);
        check(n_abort == exp_abort, {tag, " R5 abort count"}, n_abort, exp_abort);
        check(n_reset == exp_reset, {tag, " R7 reset count"}, n_reset, exp_reset);
        repeat (3) @(negedge clk);
        #1;
        check(!busy, {tag, " R9 idle after done"}, int'(busy), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        // R10 reset state
        check(!busy && !msg_done && !cmd_valid && !byte_load && !byte_unload
              && !eng_abort && !soft_reset, "R10 reset outputs",
              int'({busy, msg_done, cmd_valid, byte_load, byte_unload, eng_abort, soft_reset}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        eng_delay = 2;
        run_msg(1, 0, 0, -1, -1, 0, 0, 0, 0, 0, "R9 write1");
        run_msg(9, 0, 1, -1, -1, 0, 0, 0, 0, 0, "R3 write9 comb");
        run_msg(8, 1, 0, -1, -1, 0, 0, 0, 0, 0, "R4 read8");
        run_msg(6, 1, 1, -1, -1, 0, 0, 0, 0, 0, "R2 read6 comb");
        eng_delay = 5;
        run_msg(9, 0, 0, -1, -1, 0, 0, 0, 0, 1, "R9 ignore start while busy");
        eng_delay = 1;
        run_msg(255, 0, 0, -1, -1, 0, 0, 0, 0, 0, "R1 write255");

        // R5 short count on last chunk, plain message: no abort
        run_msg(6, 0, 0, 1, -1, 3, 1, 0, 0, 0, "R5 short last");
        // R5 short count on first of two chunks: abort, bus frees early
        run_msg(6, 1, 0, 0, -1, 2, 1, 1, 0, 0, "R5 short middle");
        // R5 short count on last chunk of combined message: abort
        run_msg(3, 0, 1, 0, -1, 1, 1, 1, 0, 0, "R5 short comb");

        // R6 timeout, bus frees within window
        run_msg(8, 0, 0, -1, 1, 3, 2, 1, 0, 0, "R6 timeout");
        check(abort_cyc - cmd_cyc == TIMEOUT + 1, "R6 timeout latency",
              abort_cyc - cmd_cyc, TIMEOUT + 1);
        // R7 timeout, bus never frees: soft reset
        run_msg(5, 1, 0, -1, 0, 100000, 2, 1, 1, 0, "R7 stuck bus");
        check(reset_cyc - abort_cyc == FREE_WAIT + 1, "R7 reset latency",
              reset_cyc - abort_cyc, FREE_WAIT + 1);
        free_timer = -1;
        @(negedge clk);
        bus_free = 1'b1;

        // R8 zero length
        clear_counts();
        @(negedge clk);
        msg_start = 1'b1; msg_len = '0; msg_rd = 1'b0; msg_comb = 1'b0;
        #1;
        check(msg_done && msg_status == 2'd3, "R8 empty done same cycle",
              int'({msg_done, msg_status}), 7);
        check(!busy, "R8 busy stays low", int'(busy), 0);
        @(negedge clk);
        msg_start = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        check(n_cmd == 0 && !busy, "R8 no command issued", n_cmd, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule